// File: doc/BRIEF.md
# Two-Event Powered-Device Classification Sequencer

This block sequences the classification phase of one power-over-Ethernet source port after a device has been detected. When `start` is pulsed, it either skips classification or runs a first class probe through a request/done handshake with a measurement stage. If that probe returns the top class (4) and the two-event option is on, it holds a mark-voltage request for a fixed pause and then runs a second probe. After the final probe it decides whether to grant power or to ask for detection to restart.

The port status class always shows the most recent probe result. A high-power flag reports that the second cycle ran. In automatic mode the final class also drives the threshold-select output used by the current-limit logic. A probe with no answer within a bounded number of cycles ends the sequence with a class fault.

Top module: `pd_class_seq`

## Requirements
- R1: A `start` accepted while `class_en` is low or `shutdown` is high runs no probe. `seq_done` pulses in the next cycle. `power_grant` pulses with it only when `auto_mode` is high and `shutdown` is low. `status_class` keeps its value, and in automatic mode `thresh_class` becomes 0.
- R2: An accepted `start` with classification enabled raises `probe_req` in the next cycle. `probe_req` stays high until the cycle after `probe_done` is sampled. The normalized probe result appears on `status_class` in that same cycle.
- R3: Measured codes 5, 6 and 7 are treated as class 0. Codes 0 to 4 are kept as they are.
- R4: If the first result is class 0 to 3, or `two_event_en` is low, no second probe runs. `mark_req` stays low and `seq_done` pulses in the cycle after the first `probe_done`.
- R5: If the first result is class 4 and `two_event_en` is high, `mark_req` is high for exactly MARK_CYCLES cycles, starting in the cycle after the first `probe_done`. `probe_req` then rises for the second probe. `probe_req` and `mark_req` are never high together.
- R6: `hp_flag` is cleared when a sequence starts. It is set when the second probe begins and holds until the next start.
- R7: After a second probe, `status_class` shows the second result, not the first.
- R8: In automatic mode, `power_grant` pulses for one cycle together with `seq_done` whenever classification completes. The single exception is class 4 followed by class 0 to 3. In that case `restart_det` pulses instead and no power is granted.
- R9: In automatic mode, `thresh_class` takes the final class at completion. When `auto_mode` is low, `thresh_class` is left unchanged and neither `power_grant` nor `restart_det` pulses.
- R10: If `probe_done` is absent for PROBE_TIMEOUT consecutive cycles of a probe, then `class_fault` and `seq_done` rise in the next cycle and no power is granted. `class_fault` holds until the next accepted `start`.
- R11: A `start` while a sequence is running is ignored. A `probe_done` while no probe is requested changes nothing.
- R12: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Detection succeeded; begin classification |
| class_en | input | 1 | Per-port classification enable |
| shutdown | input | 1 | Port in shutdown |
| two_event_en | input | 1 | Allow the second classification cycle |
| auto_mode | input | 1 | Automatic power decision mode |
| probe_done | input | 1 | Measurement stage finished a probe |
| probe_class | input | 3 | Measured class code |
| probe_req | output | 1 | Request a class probe |
| mark_req | output | 1 | Request the mark voltage level |
| status_class | output | 3 | Result of the most recent probe |
| hp_flag | output | 1 | Second classification cycle was run |
| power_grant | output | 1 | One-cycle power-on decision |
| restart_det | output | 1 | One-cycle request to restart detection |
| thresh_class | output | 3 | Class used to select current thresholds |
| class_fault | output | 1 | A probe timed out |
| seq_done | output | 1 | One-cycle end-of-sequence marker |

## Verification
Every result is registered once. The verdict pulses, the status class and the threshold class therefore appear one cycle after the clock edge that samples `start` (skip path) or the final `probe_done`. The mark request lasts exactly MARK_CYCLES cycles, and the fault appears one cycle after the PROBE_TIMEOUT-th unanswered edge. The bench drives inputs and samples outputs on the falling edge. It takes each result at the first falling edge after the deciding rising edge and counts mark-request cycles one falling edge at a time. It also checks the edge just before each due cycle, for example that `class_fault` is still low one cycle before the timeout expires.

// File: rtl/pd_class_seq_pkg.sv
package pd_class_seq_pkg;
   localparam int CLS_W = 3;
   localparam logic [CLS_W-1:0] CLS_TOP = 3'd4;

   typedef logic [CLS_W-1:0] cls_t;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PROBE_A = 2'd1,
      ST_MARK    = 2'd2,
      ST_PROBE_B = 2'd3
   } seq_st_e;
endpackage

// File: rtl/pd_class_norm.sv
module pd_class_norm
   import pd_class_seq_pkg::*;
#(
   parameter int TOP_CLASS = 4,
   parameter bit SATURATE  = 1'b0
) (
   input  cls_t raw_cls,
   output cls_t norm_cls
);
   localparam cls_t TOP_C = cls_t'(TOP_CLASS);

   generate
      if (TOP_CLASS < 1 || TOP_CLASS > (1 << CLS_W) - 1) begin : g_bad_top
         $error("pd_class_norm: TOP_CLASS out of range");
      end
      if (SATURATE) begin : g_sat
         assign norm_cls = (raw_cls > TOP_C) ? TOP_C : raw_cls;
      end else begin : g_zero
         assign norm_cls = (raw_cls > TOP_C) ? '0 : raw_cls;
      end
   endgenerate
endmodule

// File: rtl/pd_class_ticker.sv
module pd_class_ticker #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CNT_MAX = '1;

   generate
      if (W < 1) begin : g_bad_w
         $error("pd_class_ticker: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt <= '0;
      else if (cnt != CNT_MAX)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pd_class_verdict.sv
module pd_class_verdict
   import pd_class_seq_pkg::*;
(
   input  logic fin,
   input  logic auto_mode,
   input  logic skip_path,
   input  logic tmo,
   input  logic shutdown,
   input  logic second,
   input  cls_t cls,
   output logic grant,
   output logic restart,
   output logic thr_load,
   output cls_t thr_val
);
   logic decide;
   logic bad_pair;

   always_comb begin
      decide   = fin && auto_mode && !tmo;
      bad_pair = second && (cls != CLS_TOP);
      grant    = decide && !(skip_path && shutdown) && !bad_pair;
      restart  = decide && bad_pair && !skip_path;
      thr_load = decide;
      thr_val  = skip_path ? '0 : cls;
   end
endmodule

// File: rtl/pd_class_seq.sv
module pd_class_seq
   import pd_class_seq_pkg::*;
#(
   parameter int MARK_CYCLES   = 8,
   parameter int PROBE_TIMEOUT = 64,
   parameter bit SAT_CLASS     = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       class_en,
   input  logic       shutdown,
   input  logic       two_event_en,
   input  logic       auto_mode,
   input  logic       probe_done,
   input  logic [2:0] probe_class,
   output logic       probe_req,
   output logic       mark_req,
   output logic [2:0] status_class,
   output logic       hp_flag,
   output logic       power_grant,
   output logic       restart_det,
   output logic [2:0] thresh_class,
   output logic       class_fault,
   output logic       seq_done
);
   localparam int SPAN  = (MARK_CYCLES > PROBE_TIMEOUT) ? MARK_CYCLES : PROBE_TIMEOUT;
   localparam int CNT_W = $clog2(SPAN + 1);
   localparam logic [CNT_W-1:0] MARK_LAST = CNT_W'(MARK_CYCLES - 1);
   localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(PROBE_TIMEOUT - 1);

   generate
      if (MARK_CYCLES < 1) begin : g_bad_mark
         $error("pd_class_seq: MARK_CYCLES must be at least 1");
      end
      if (PROBE_TIMEOUT < 2) begin : g_bad_tmo
         $error("pd_class_seq: PROBE_TIMEOUT must be at least 2");
      end
   endgenerate

   seq_st_e          state_q, state_d;
   logic [CNT_W-1:0] cnt;
   cls_t             cls_n;
   cls_t             status_q, thresh_q;
   logic             hp_q, fault_q, grant_q, restart_q, done_q;

   logic accept, skip, in_probe, done_ok, tmo, mark_end, go_mark, fin, second;
   logic v_grant, v_restart, v_thr_load;
   cls_t v_thr_val;

   pd_class_norm #(
      .TOP_CLASS (int'(CLS_TOP)),
      .SATURATE  (SAT_CLASS)
   ) u_norm (
      .raw_cls  (probe_class),
      .norm_cls (cls_n)
   );

   pd_class_ticker #(.W(CNT_W)) u_ticker (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_d != state_q),
      .cnt   (cnt)
   );

   always_comb begin
      accept   = (state_q == ST_IDLE) && start;
      skip     = !class_en || shutdown;
      in_probe = (state_q == ST_PROBE_A) || (state_q == ST_PROBE_B);
      done_ok  = in_probe && probe_done;
      tmo      = in_probe && !probe_done && (cnt == TMO_LAST);
      mark_end = (state_q == ST_MARK) && (cnt == MARK_LAST);
      go_mark  = (state_q == ST_PROBE_A) && done_ok && (cls_n == CLS_TOP) && two_event_en;
      second   = (state_q == ST_PROBE_B);
      fin      = (accept && skip) || (done_ok && !go_mark) || tmo;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (accept && !skip) state_d = ST_PROBE_A;
         ST_PROBE_A: if (go_mark) state_d = ST_MARK;
                     else if (done_ok || tmo) state_d = ST_IDLE;
         ST_MARK:    if (mark_end) state_d = ST_PROBE_B;
         ST_PROBE_B: if (done_ok || tmo) state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   pd_class_verdict u_verdict (
      .fin       (fin),
      .auto_mode (auto_mode),
      .skip_path (accept && skip),
      .tmo       (tmo),
      .shutdown  (shutdown),
      .second    (second),
      .cls       (cls_n),
      .grant     (v_grant),
      .restart   (v_restart),
      .thr_load  (v_thr_load),
      .thr_val   (v_thr_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         status_q  <= '0;
         thresh_q  <= '0;
         hp_q      <= 1'b0;
         fault_q   <= 1'b0;
         grant_q   <= 1'b0;
         restart_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         state_q   <= state_d;
         grant_q   <= v_grant;
         restart_q <= v_restart;
         done_q    <= fin;
         if (done_ok)    status_q <= cls_n;
         if (v_thr_load) thresh_q <= v_thr_val;
         if (accept)        hp_q <= 1'b0;
         else if (mark_end) hp_q <= 1'b1;
         if (accept)   fault_q <= 1'b0;
         else if (tmo) fault_q <= 1'b1;
      end
   end

   assign probe_req    = (state_q == ST_PROBE_A) || (state_q == ST_PROBE_B);
   assign mark_req     = (state_q == ST_MARK);
   assign status_class = status_q;
   assign hp_flag      = hp_q;
   assign power_grant  = grant_q;
   assign restart_det  = restart_q;
   assign thresh_class = thresh_q;
   assign class_fault  = fault_q;
   assign seq_done     = done_q;
endmodule

// File: rtl/pd_class_seq_chk.sv
module pd_class_seq_chk #(
   parameter int MARK_CYCLES = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       probe_req,
   input logic       mark_req,
   input logic [2:0] status_class,
   input logic       hp_flag,
   input logic       power_grant,
   input logic       restart_det,
   input logic       class_fault,
   input logic       seq_done
);
   int mark_run;

   always_ff @(posedge clk) begin
      if (!rst_n)        mark_run <= 0;
      else if (mark_req) mark_run <= mark_run + 1;
      else               mark_run <= 0;
   end

   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(probe_req && mark_req)); // R5

   AST_MARK_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mark_req) |-> (mark_run == MARK_CYCLES)); // R5

   AST_MARK_THEN_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mark_req) |-> (probe_req && hp_flag)); // R6

   AST_GRANT_XOR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !(power_grant && restart_det)); // R8

   AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      power_grant |=> !power_grant); // R8

   AST_GRANT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      power_grant |-> seq_done); // R8

   AST_RESTART_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      restart_det |-> (hp_flag && status_class != 3'd4 && seq_done)); // R8

   AST_FAULT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (class_fault && seq_done) |-> !power_grant); // R10

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> (!probe_req && !mark_req)); // R2
endmodule

bind pd_class_seq pd_class_seq_chk #(.MARK_CYCLES(MARK_CYCLES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .probe_req    (probe_req),
   .mark_req     (mark_req),
   .status_class (status_class),
   .hp_flag      (hp_flag),
   .power_grant  (power_grant),
   .restart_det  (restart_det),
   .class_fault  (class_fault),
   .seq_done     (seq_done)
);

// File: tb/pd_class_seq_bench.sv
module pd_class_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MARK_CYC   = 8;
   localparam int TMO_CYC    = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, class_en = 1'b0, shutdown = 1'b0;
   logic       two_event_en = 1'b0, auto_mode = 1'b0, probe_done = 1'b0;
   logic [2:0] probe_class = '0;
   logic       probe_req, mark_req, hp_flag, power_grant, restart_det, class_fault, seq_done;
   logic [2:0] status_class, thresh_class;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int exp_thr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pd_class_seq #(.MARK_CYCLES(MARK_CYC), .PROBE_TIMEOUT(TMO_CYC)) u_pd_class_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .class_en(class_en),
      .shutdown(shutdown), .two_event_en(two_event_en), .auto_mode(auto_mode),
      .probe_done(probe_done), .probe_class(probe_class),
      .probe_req(probe_req), .mark_req(mark_req), .status_class(status_class),
      .hp_flag(hp_flag), .power_grant(power_grant), .restart_det(restart_det),
      .thresh_class(thresh_class), .class_fault(class_fault), .seq_done(seq_done)
   );

   typedef struct packed {
      logic       en, sd, te, au;
      logic [2:0] c1, c2;
      logic       e_two, e_grant, e_rst;
      logic [2:0] e_st;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{1'b1,1'b0,1'b1,1'b1,3'd2,3'd0,1'b0,1'b1,1'b0,3'd2},
      '{1'b1,1'b0,1'b1,1'b1,3'd4,3'd4,1'b1,1'b1,1'b0,3'd4},
      '{1'b1,1'b0,1'b1,1'b1,3'd4,3'd1,1'b1,1'b0,1'b1,3'd1},
      '{1'b1,1'b0,1'b0,1'b1,3'd4,3'd0,1'b0,1'b1,1'b0,3'd4},
      '{1'b0,1'b0,1'b1,1'b1,3'd3,3'd0,1'b0,1'b1,1'b0,3'd4},
      '{1'b1,1'b0,1'b1,1'b1,3'd6,3'd0,1'b0,1'b1,1'b0,3'd0},
      '{1'b1,1'b1,1'b1,1'b1,3'd2,3'd0,1'b0,1'b0,1'b0,3'd0},
      '{1'b1,1'b0,1'b1,1'b0,3'd4,3'd2,1'b1,1'b0,1'b0,3'd2},
      '{1'b1,1'b0,1'b1,1'b1,3'd4,3'd7,1'b1,1'b0,1'b1,3'd0},
      '{1'b1,1'b0,1'b1,1'b1,3'd5,3'd0,1'b0,1'b1,1'b0,3'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic give_done(input logic [2:0] c);
      probe_done  = 1'b1;
      probe_class = c;
      @(negedge clk);
      probe_done  = 1'b0;
   endtask

   task automatic final_checks(input string tag, input vec_t v);
      chk({tag, " R8 seq_done"}, seq_done, 1);
      chk({tag, " R8 power_grant"}, power_grant, v.e_grant);
      chk({tag, " R8 restart_det"}, restart_det, v.e_rst);
      chk({tag, " R7 status_class"}, status_class, v.e_st);
      chk({tag, " R9 thresh_class"}, thresh_class, exp_thr);
      chk({tag, " R6 hp_flag"}, hp_flag, v.e_two);
      chk({tag, " R2 probe_req low"}, probe_req, 0);
   endtask

   task automatic run_vec(input int i);
      vec_t v = TBL[i];
      string tag = $sformatf("vec%0d", i);
      int mcount = 0;
      @(negedge clk);
      class_en = v.en; shutdown = v.sd; two_event_en = v.te; auto_mode = v.au;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (!v.en || v.sd) begin
         if (v.au) exp_thr = 0;
         chk({tag, " R1 no probe"}, probe_req, 0);
         final_checks(tag, v);
      end else begin
         chk({tag, " R2 probe_req"}, probe_req, 1);
         chk({tag, " R6 hp cleared"}, hp_flag, 0);
         repeat (2) @(negedge clk);
         chk({tag, " R2 probe held"}, probe_req, 1);
         give_done(v.c1);
         if (v.e_two) begin
            chk({tag, " R7 first result shown"}, status_class, 4);
            chk({tag, " R5 mark_req"}, mark_req, 1);
            while (mark_req && mcount < 1000) begin
               mcount++;
               @(negedge clk);
            end
            chk({tag, " R5 mark length"}, mcount, MARK_CYC);
            chk({tag, " R5 second probe"}, probe_req, 1);
            chk({tag, " R6 hp set"}, hp_flag, 1);
            give_done(v.c2);
         end else begin
            chk({tag, " R4 no mark"}, mark_req, 0);
         end
         if (v.au) exp_thr = v.e_st;
         final_checks(tag, v);
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R12: outputs while reset is held
      chk("R12 probe_req", probe_req, 0);
      chk("R12 mark_req", mark_req, 0);
      chk("R12 status_class", status_class, 0);
      chk("R12 hp_flag", hp_flag, 0);
      chk("R12 power_grant", power_grant, 0);
      chk("R12 restart_det", restart_det, 0);
      chk("R12 thresh_class", thresh_class, 0);
      chk("R12 class_fault", class_fault, 0);
      chk("R12 seq_done", seq_done, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) run_vec(i);

      // R11: stray probe_done while idle changes nothing
      @(negedge clk);
      give_done(3'd3);
      chk("R11 stray done status", status_class, 0);
      chk("R11 stray done seq_done", seq_done, 0);

      // R11: start while busy is ignored; R3 class 3 kept
      class_en = 1; shutdown = 0; two_event_en = 1; auto_mode = 1;
      start = 1'b1;
      @(negedge clk);
      chk("R11 busy probe_req", probe_req, 1);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      give_done(3'd3);
      chk("R3 class 3 status", status_class, 3);
      chk("R11 busy grant", power_grant, 1);
      @(negedge clk);
      chk("R11 no restart of sequence", probe_req, 0);
      chk("R11 no second done", seq_done, 0);

      // R10: probe timeout
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (TMO_CYC - 1) @(negedge clk);
      chk("R10 fault not yet", class_fault, 0);
      chk("R10 probe still held", probe_req, 1);
      @(negedge clk);
      chk("R10 fault set", class_fault, 1);
      chk("R10 seq_done", seq_done, 1);
      chk("R10 no grant", power_grant, 0);
      chk("R10 probe dropped", probe_req, 0);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 fault cleared", class_fault, 0);
      give_done(3'd1);
      chk("R4 completion after clear", seq_done, 1);

      repeat (2) @(negedge clk);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule